// File: doc/BRIEF.md
# Signature-driven test pattern selector

After an error checker has recorded which of its monitored groups failed, this block turns that failure signature into a short, targeted test sequence. It holds a constant assignment table and an on-chip pattern store. The table gives each signature bit a fixed list of pattern indices. The store holds the full pattern superset, which is built so that each fault is detected several times.

On a start pulse the block latches the signature. It walks the set bits from the lowest upward, and for each one it streams out the pattern words that its table entry names. The words leave through a valid/ready handshake, ready to be broadcast to every identical core. A busy flag covers the whole run. A single-cycle done pulse marks its end.

Both the table and the store are filled at elaboration from compact formulas in a shared package.

Top module: `sig_pattern_sel`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `busy_o`, `pat_valid_o` and `done_o` are all 0.
- R2: Entry `b` of the assignment table (one entry per signature bit, `b` = 0 is the least significant bit) lists `PER_ENTRY` (default 20) pattern indices. Slot `k` of entry `b` holds index `(b*5 + k*3) mod DEPTH`. The slots are issued in order, `k` = 0 first.
- R3: The word issued for index `i` is the low `PAT_W` bits of `(i*40503) XOR 50085`.
- R4: When several signature bits are set, their entries are served in ascending bit order. Every pattern of one entry is transferred before the first pattern of the next. Exactly `PER_ENTRY` words are transferred per set bit.
- R5: A word is transferred on a clock edge where `pat_valid_o` and `pat_ready_i` are both 1. While valid is 1 and ready is 0, `pat_valid_o` stays 1 and `pat_data_o` stays unchanged.
- R6: `done_o` is 1 for exactly one cycle. For a non-zero signature, that cycle is the one that follows the edge of the last transfer. In that same cycle `busy_o` is 0.
- R7: A start with an all-zero signature raises `done_o` in the next cycle, leaves `busy_o` at 0 and issues no word.
- R8: A start pulse while `busy_o` is 1 is ignored: the run in progress continues with its original signature and produces a single done pulse.
- R9: `busy_o` is 1 from the cycle after an accepted non-zero start until the last transfer. `pat_valid_o` is never 1 while `busy_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Single-cycle request to serve `sig_i` |
| sig_i | input | SIG_W | Failure signature, one bit per checker group |
| pat_data_o | output | PAT_W | Current pattern word |
| pat_valid_o | output | 1 | `pat_data_o` holds a word to transfer |
| pat_ready_i | input | 1 | Consumer accepts the word this cycle |
| busy_o | output | 1 | A selection run is in progress |
| done_o | output | 1 | One-cycle pulse at the end of a run |

## Verification
The bench targets four risks:
- **Entry boundaries.** The wrong word is picked at the switch from one set bit to the next, or at the top bit. An off-by-one slot counter would emit 19 or 21 words, or repeat an index, and the queued expected words would mismatch.
- **Back-pressure.** Ready is stalled in several patterns, including mostly-low. A design that advances without a handshake, or lets data slip during a stall, breaks word order or stability.
- **Zero signature.** A design that waits for a set bit would hang, or would raise busy, on an all-zero signature.
- **Restart while busy.** A design that relatches the signature on a start pulse during a run would emit a different stream or an extra done pulse.

// File: rtl/sig_pattern_sel_pkg.sv
package sig_pattern_sel_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_READ = 2'd1,
    ST_SHOW = 2'd2
  } sel_state_e;

  // Assignment table slot content: pattern index for bit b, slot k.
  function automatic int unsigned sel_index(input int unsigned b,
                                            input int unsigned k,
                                            input int unsigned depth);
    return (b * 5 + k * 3) % depth;
  endfunction

  // Superset pattern word for index i (caller keeps the low bits).
  function automatic logic [31:0] sel_word(input int unsigned i);
    return (32'(i) * 32'd40503) ^ 32'd50085;
  endfunction

endpackage

// File: rtl/sel_lowest_bit.sv
module sel_lowest_bit #(
  parameter int unsigned WIDTH = 8,
  localparam int unsigned IW = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic [WIDTH-1:0] vec_i,
  output logic             any_o,
  output logic [IW-1:0]    idx_o
);
  always_comb begin
    any_o = |vec_i;
    idx_o = '0;
    for (int i = WIDTH - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/sel_index_rom.sv
module sel_index_rom #(
  parameter int unsigned SIG_W     = 8,
  parameter int unsigned PER_ENTRY = 20,
  parameter int unsigned DEPTH     = 64,
  localparam int unsigned ENTRIES = SIG_W * PER_ENTRY,
  localparam int unsigned TAB_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int unsigned IDX_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [TAB_W-1:0] addr_i,
  output logic [IDX_W-1:0] idx_o
);
  import sig_pattern_sel_pkg::*;

  logic [IDX_W-1:0] tab [ENTRIES];

  initial begin
    for (int b = 0; b < int'(SIG_W); b++) begin
      for (int k = 0; k < int'(PER_ENTRY); k++) begin
        tab[b * PER_ENTRY + k] = IDX_W'(sel_index(b, k, DEPTH));
      end
    end
  end

  assign idx_o = tab[addr_i];
endmodule

// File: rtl/sel_pattern_rom.sv
module sel_pattern_rom #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned PAT_W = 16,
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             en_i,
  input  logic [IDX_W-1:0] addr_i,
  output logic [PAT_W-1:0] data_o
);
  import sig_pattern_sel_pkg::*;

  logic [PAT_W-1:0] mem [DEPTH];
  logic [PAT_W-1:0] data_q;

  initial begin
    for (int i = 0; i < int'(DEPTH); i++) begin
      mem[i] = PAT_W'(sel_word(i));
    end
  end

  always_ff @(posedge clk_i) begin
    if (en_i) data_q <= mem[addr_i];
  end

  assign data_o = data_q;
endmodule

// File: rtl/sig_pattern_sel.sv
module sig_pattern_sel #(
  parameter int unsigned SIG_W     = 8,
  parameter int unsigned PER_ENTRY = 20,
  parameter int unsigned DEPTH     = 64,
  parameter int unsigned PAT_W     = 16
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             start_i,
  input  logic [SIG_W-1:0] sig_i,
  output logic [PAT_W-1:0] pat_data_o,
  output logic             pat_valid_o,
  input  logic             pat_ready_i,
  output logic             busy_o,
  output logic             done_o
);
  import sig_pattern_sel_pkg::*;

  localparam int unsigned BIT_W   = (SIG_W > 1) ? $clog2(SIG_W) : 1;
  localparam int unsigned K_W     = (PER_ENTRY > 1) ? $clog2(PER_ENTRY) : 1;
  localparam int unsigned ENTRIES = SIG_W * PER_ENTRY;
  localparam int unsigned TAB_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int unsigned IDX_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [K_W-1:0] K_LAST = K_W'(PER_ENTRY - 1);

  sel_state_e       state_q;
  logic [SIG_W-1:0] pending_q;
  logic [BIT_W-1:0] cur_bit_q;
  logic [K_W-1:0]   k_q;
  logic             valid_q;
  logic             done_q;

  logic             start_any, rest_any;
  logic [BIT_W-1:0] start_idx, rest_idx;
  logic [SIG_W-1:0] rest_vec;
  logic [TAB_W-1:0] tab_addr;
  logic [IDX_W-1:0] pat_idx;

  // Pending set bits once the entry in service has been retired.
  assign rest_vec = pending_q & ~(SIG_W'(1) << cur_bit_q);
  assign tab_addr = TAB_W'(int'(cur_bit_q) * int'(PER_ENTRY) + int'(k_q));

  sel_lowest_bit #(.WIDTH(SIG_W)) u_start_enc (
    .vec_i (sig_i),
    .any_o (start_any),
    .idx_o (start_idx)
  );

  sel_lowest_bit #(.WIDTH(SIG_W)) u_rest_enc (
    .vec_i (rest_vec),
    .any_o (rest_any),
    .idx_o (rest_idx)
  );

  sel_index_rom #(
    .SIG_W     (SIG_W),
    .PER_ENTRY (PER_ENTRY),
    .DEPTH     (DEPTH)
  ) u_tab (
    .addr_i (tab_addr),
    .idx_o  (pat_idx)
  );

  sel_pattern_rom #(
    .DEPTH (DEPTH),
    .PAT_W (PAT_W)
  ) u_store (
    .clk_i  (clk_i),
    .en_i   (state_q == ST_READ),
    .addr_i (pat_idx),
    .data_o (pat_data_o)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state_q   <= ST_IDLE;
      pending_q <= '0;
      cur_bit_q <= '0;
      k_q       <= '0;
      valid_q   <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            if (!start_any) begin
              done_q <= 1'b1;
            end else begin
              pending_q <= sig_i;
              cur_bit_q <= start_idx;
              k_q       <= '0;
              state_q   <= ST_READ;
            end
          end
        end
        ST_READ: begin
          valid_q <= 1'b1;
          state_q <= ST_SHOW;
        end
        ST_SHOW: begin
          if (pat_ready_i) begin
            valid_q <= 1'b0;
            if (k_q == K_LAST) begin
              k_q       <= '0;
              pending_q <= rest_vec;
              if (rest_any) begin
                cur_bit_q <= rest_idx;
                state_q   <= ST_READ;
              end else begin
                done_q  <= 1'b1;
                state_q <= ST_IDLE;
              end
            end else begin
              k_q     <= k_q + 1'b1;
              state_q <= ST_READ;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign pat_valid_o = valid_q;
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = done_q;
endmodule

// File: rtl/sig_pattern_sel_chk.sv
module sig_pattern_sel_chk #(
  parameter int unsigned SIG_W = 8,
  parameter int unsigned PAT_W = 16
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             start_i,
  input logic [SIG_W-1:0] sig_i,
  input logic [PAT_W-1:0] pat_data_o,
  input logic             pat_valid_o,
  input logic             pat_ready_i,
  input logic             busy_o,
  input logic             done_o
);
  p_stall_hold_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    (pat_valid_o && !pat_ready_i) |=> (pat_valid_o && $stable(pat_data_o)));

  p_done_single_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    done_o |=> !done_o);

  p_done_idle_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    done_o |-> !busy_o);

  p_zero_sig_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    (start_i && !busy_o && (sig_i == '0)) |=> (done_o && !busy_o));

  p_busy_start_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    (start_i && busy_o && !(pat_valid_o && pat_ready_i)) |=> busy_o);

  p_valid_in_run_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    pat_valid_o |-> busy_o);

  p_accept_start_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    (start_i && !busy_o && (sig_i != '0)) |=> busy_o);
endmodule

bind sig_pattern_sel sig_pattern_sel_chk #(
  .SIG_W (SIG_W),
  .PAT_W (PAT_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_i       (rst_i),
  .start_i     (start_i),
  .sig_i       (sig_i),
  .pat_data_o  (pat_data_o),
  .pat_valid_o (pat_valid_o),
  .pat_ready_i (pat_ready_i),
  .busy_o      (busy_o),
  .done_o      (done_o)
);

// File: tb/sig_pattern_sel_tb_top.sv
`timescale 1ns/1ps
module sig_pattern_sel_tb_top;
  localparam int SIG_W = 8;
  localparam int PER   = 20;
  localparam int DEPTH = 64;
  localparam int PAT_W = 16;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start = 1'b0;
  logic [SIG_W-1:0] sig = '0;
  logic             ready = 1'b0;
  logic [PAT_W-1:0] pat_data;
  logic             pat_valid, busy, done;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int ready_mode = 0;

  // Reference model state
  logic [PAT_W-1:0] exp_q[$];
  bit m_busy = 0;
  bit m_done = 0;
  bit last_stall = 0;
  logic [PAT_W-1:0] last_data = '0;

  always #2.5 clk = ~clk;

  sig_pattern_sel dut_i (
    .clk_i       (clk),
    .rst_i       (rst),
    .start_i     (start),
    .sig_i       (sig),
    .pat_data_o  (pat_data),
    .pat_valid_o (pat_valid),
    .pat_ready_i (ready),
    .busy_o      (busy),
    .done_o      (done)
  );

  function automatic logic [PAT_W-1:0] word_of(input int i);
    int unsigned v;
    v = (i * 40503) ^ 50085;
    return PAT_W'(v);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Compare on every clock edge, using the pre-edge values of the outputs.
  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      exp_q.delete();
      m_busy = 0;
      m_done = 0;
      last_stall = 0;
    end else begin
      check(busy == m_busy, "R9", "busy", busy, m_busy);
      check(done == m_done, "R6", "done", done, m_done);
      if (!m_busy) check(pat_valid == 1'b0, "R9", "valid while idle", pat_valid, 0);
      if (last_stall) begin
        check(pat_valid == 1'b1, "R5", "valid dropped in stall", pat_valid, 1);
        check(pat_data == last_data, "R5", "data moved in stall", pat_data, last_data);
      end
      last_stall = pat_valid && !ready;
      last_data  = pat_data;
      m_done = 0;
      if (pat_valid && ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R4", "extra word", pat_data, 0);
        end else begin
          logic [PAT_W-1:0] e;
          e = exp_q.pop_front();
          check(pat_data == e, "R3", "word", pat_data, e);
          if (exp_q.size() == 0) begin
            m_done = 1;
            m_busy = 0;
          end
        end
      end
      if (start && !m_busy && !m_done) begin
        if (sig == '0) begin
          m_done = 1;   // R7
        end else begin
          for (int b = 0; b < SIG_W; b++) begin
            if (sig[b]) begin
              for (int k = 0; k < PER; k++) exp_q.push_back(word_of((b * 5 + k * 3) % DEPTH));
            end
          end
          m_busy = 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    case (ready_mode)
      0: ready <= 1'b1;
      1: ready <= cyc[0];
      2: ready <= ((cyc * 7) % 5) < 3;
      default: ready <= ((cyc % 6) == 0);
    endcase
  end

  task automatic run(input logic [SIG_W-1:0] s, input int mode,
                     input bit poke, input string req);
    ready_mode = mode;
    @(negedge clk);
    start = 1'b1;
    sig = s;
    @(negedge clk);
    start = 1'b0;
    sig = 8'h00;
    if (poke) begin
      repeat (5) @(negedge clk);
      start = 1'b1;
      sig = 8'h01;   // R8: must be ignored
      @(negedge clk);
      start = 1'b0;
      sig = 8'h00;
    end
    while (!done) @(negedge clk);
    @(negedge clk);
    check(exp_q.size() == 0, req, "words left", exp_q.size(), 0);
    check(busy == 1'b0 && done == 1'b0, req, "idle after run", {busy, done}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(busy == 0 && pat_valid == 0 && done == 0, "R1", "reset outputs",
          {busy, pat_valid, done}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(busy == 0 && pat_valid == 0 && done == 0, "R1", "after reset",
          {busy, pat_valid, done}, 0);
    run(8'h01, 0, 0, "R2");          // single entry, bit 0
    run(8'b1010_0100, 1, 0, "R4");   // ascending order, toggling ready
    run(8'h00, 0, 0, "R7");          // zero signature
    check(pat_valid == 0, "R7", "no word", pat_valid, 0);
    run(8'hFF, 2, 1, "R8");          // all bits, restart poke
    run(8'h80, 3, 0, "R5");          // top bit, heavy stalls
    run(8'h11, 0, 1, "R6");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule